// File: doc/BRIEF.md
# Double-Buffered Attenuation Register Bank

This block keeps the volume settings for an audio output path. A write carries a 7-bit register address and a 9-bit data word. Each write first lands in a pending latch for its channel, so software can prepare new settings one channel at a time while the outputs keep their old values. When a write has its top data bit set, the block moves every pending value into the active registers on the same clock edge. All channels therefore change together.

There are four analog channels. Each takes a 7-bit code in steps of 1 dB. There are also several digital channels, each taking an 8-bit code in steps of 0.5 dB. One master address loads the same code and zero-cross enable into every analog pending latch at once. An analog channel whose zero-cross enable is set does not take its new code at commit. It takes it when the sign input of that channel changes, or after a fixed timeout, whichever comes first. This keeps steps in gain away from large signal values.

Top module: `attn_bank`

## Requirements
- R1: A synchronous active-low reset sets every analog code, pending and active, to 7'h6B (0 dB). It sets every digital code to 8'hFF (0 dB) and clears every zero-cross enable.
- R2: A write with data bit 8 at 0 changes only the addressed pending latch. No output changes.
- R3: A write with data bit 8 at 1 to a valid address stores its own value first. On the clock edge that samples the write, it then copies every pending latch to the active registers. Outputs without zero-cross show the new values after that edge.
- R4: Address 0Ah loads data bits 6:0 as the code and bit 7 as the zero-cross enable into the pending latches of all four analog channels.
- R5: Addresses 0Bh, 0Ch and 0Dh load data bits 7:0 into digital channels 0, 1 and 2. A digital output is channel index times 8 bits up in `dig_atten_o`.
- R6: Addresses 06h to 09h load data bits 6:0 into analog channels 0 to 3, and bit 7 into that channel's zero-cross enable. An analog output is channel index times 7 bits up in `ana_atten_o`.
- R7: After a commit with a channel's zero-cross enable set, the channel's active code stays unchanged. It takes the new code on the clock edge that first sees its `ana_sign_i` bit differ from the value of the previous cycle.
- R8: If no sign change arrives, an armed analog channel takes its new code ZC_TIMEOUT (default 1024) cycles after the commit.
- R9: Writes to addresses outside 06h to 0Dh change no latch and do not commit, even with bit 8 set.
- R10: The update bit is not stored. A later write with bit 8 at 0 does not commit values that are already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | 7 | Register address |
| wr_data_i | input | 9 | Data word; bit 8 is the update bit |
| ana_sign_i | input | NUM_ANA | Sign of each analog channel's signal |
| ana_atten_o | output | 7*NUM_ANA | Active analog codes, channel 0 in the low bits |
| dig_atten_o | output | 8*NUM_DIG | Active digital codes, channel 0 in the low bits |

## Verification
The bound checker watches the digital path on every cycle. It checks that a write without the update bit, or a write to an unused address, leaves the digital outputs unchanged on the next edge. It checks that a committing digital write shows its own value on the next edge, and that every output sits at its 0 dB default after a reset edge. The analog zero-cross behaviour can only be shown by the bench scenarios. These cover the hold-then-apply on a sign change, the timeout release, the master write arming all four channels while only one sign toggles, and the pending values that survive ignored writes.

// File: rtl/attn_pkg.sv
// Package: shared widths, reset codes and register addresses for the
// attenuation bank. Assumes the address layout is fixed: analog
// channels are contiguous from ANA_BASE, digital channels from DIG_BASE.
package attn_pkg;
    localparam int ADDR_W  = 7;
    localparam int WORD_W  = 9;
    localparam int ANA_W   = 7;
    localparam int DIG_W   = 8;
    localparam int UPD_BIT = 8;
    localparam int ZC_BIT  = 7;

    localparam logic [ANA_W-1:0]  ANA_RESET  = 7'h6B;
    localparam logic [DIG_W-1:0]  DIG_RESET  = 8'hFF;
    localparam logic [ADDR_W-1:0] ANA_BASE   = 7'h06;
    localparam logic [ADDR_W-1:0] MASTER_ADR = 7'h0A;
    localparam logic [ADDR_W-1:0] DIG_BASE   = 7'h0B;
endpackage

// File: rtl/attn_ana_chan.sv
// Module: one analog attenuation channel with a pending latch, an
// active register and zero-cross gating. Assumes commit_i and ld_i
// can be high in the same cycle; the loaded value then takes part
// in the commit. The sign input is synchronous to clk.
module attn_ana_chan
    import attn_pkg::*;
#(
    parameter int ZC_TIMEOUT = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [ANA_W-1:0] code_i,
    input  logic             zc_i,
    input  logic             commit_i,
    input  logic             sign_i,
    output logic [ANA_W-1:0] atten_o
);
    localparam int CNT_W = $clog2(ZC_TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ZC_TIMEOUT - 1);

    logic [ANA_W-1:0] pend_code_q, pend_code_d;
    logic             pend_zc_q, pend_zc_d;
    logic [ANA_W-1:0] target_q, active_q;
    logic             armed_q, sign_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sign_edge;

    // Next pending values: the current write overrides the stored latch.
    always_comb begin
        pend_code_d = ld_i ? code_i : pend_code_q;
        pend_zc_d   = ld_i ? zc_i   : pend_zc_q;
    end

    assign sign_edge = (sign_i != sign_q);

    // Pending latch and previous-sign register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_code_q <= ANA_RESET;
            pend_zc_q   <= 1'b0;
            sign_q      <= 1'b0;
        end else begin
            pend_code_q <= pend_code_d;
            pend_zc_q   <= pend_zc_d;
            sign_q      <= sign_i;
        end
    end

    // Active register: immediate load, or arm and wait for zero cross/timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= ANA_RESET;
            target_q <= ANA_RESET;
            armed_q  <= 1'b0;
            cnt_q    <= '0;
        end else if (commit_i) begin
            target_q <= pend_code_d;
            cnt_q    <= '0;
            if (pend_zc_d) begin
                armed_q <= 1'b1;
            end else begin
                armed_q  <= 1'b0;
                active_q <= pend_code_d;
            end
        end else if (armed_q) begin
            if (sign_edge || cnt_q == CNT_LAST) begin
                active_q <= target_q;
                armed_q  <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign atten_o = active_q;
endmodule

// File: rtl/attn_dig_chan.sv
// Module: one digital attenuation channel, a pending latch plus an
// active register. Assumes a load and a commit in the same cycle
// commit the loaded value.
module attn_dig_chan
    import attn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [DIG_W-1:0] code_i,
    input  logic             commit_i,
    output logic [DIG_W-1:0] atten_o
);
    logic [DIG_W-1:0] pend_q, pend_d, active_q;

    // Next pending value with the current write folded in.
    assign pend_d = ld_i ? code_i : pend_q;

    // Pending and active registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= DIG_RESET;
            active_q <= DIG_RESET;
        end else begin
            pend_q <= pend_d;
            if (commit_i) active_q <= pend_d;
        end
    end

    assign atten_o = active_q;
endmodule

// File: rtl/attn_bank.sv
// Module: top of the attenuation register bank. Decodes writes into
// per-channel loads and a global commit. Assumes at most one write
// per cycle and that the address is valid while wr_en_i is high.
module attn_bank
    import attn_pkg::*;
#(
    parameter int NUM_ANA    = 4,
    parameter int NUM_DIG    = 3,
    parameter int ZC_TIMEOUT = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [WORD_W-1:0]        wr_data_i,
    input  logic [NUM_ANA-1:0]       ana_sign_i,
    output logic [ANA_W*NUM_ANA-1:0] ana_atten_o,
    output logic [DIG_W*NUM_DIG-1:0] dig_atten_o
);
    localparam logic [ADDR_W-1:0] LAST_ADR = DIG_BASE + ADDR_W'(NUM_DIG - 1);

    logic addr_ok;
    logic commit;

    // Valid address window and the global commit strobe.
    always_comb begin
        addr_ok = (wr_addr_i >= ANA_BASE) && (wr_addr_i <= LAST_ADR);
        commit  = wr_en_i && addr_ok && wr_data_i[UPD_BIT];
    end

    for (genvar i = 0; i < NUM_ANA; i++) begin : g_ana
        logic ld;
        // Load on the channel's own address or the master address.
        assign ld = wr_en_i && ((wr_addr_i == ANA_BASE + ADDR_W'(i)) ||
                                (wr_addr_i == MASTER_ADR));
        attn_ana_chan #(.ZC_TIMEOUT(ZC_TIMEOUT)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_i     (ld),
            .code_i   (wr_data_i[ANA_W-1:0]),
            .zc_i     (wr_data_i[ZC_BIT]),
            .commit_i (commit),
            .sign_i   (ana_sign_i[i]),
            .atten_o  (ana_atten_o[ANA_W*i +: ANA_W])
        );
    end

    for (genvar j = 0; j < NUM_DIG; j++) begin : g_dig
        logic ld;
        // Load on the channel's own address.
        assign ld = wr_en_i && (wr_addr_i == DIG_BASE + ADDR_W'(j));
        attn_dig_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_i     (ld),
            .code_i   (wr_data_i[DIG_W-1:0]),
            .commit_i (commit),
            .atten_o  (dig_atten_o[DIG_W*j +: DIG_W])
        );
    end
endmodule

// File: rtl/attn_bank_chk.sv
// Module: port-level checker for attn_bank, attached by bind.
// Assumes NUM_DIG >= 1 and the digital channels have no zero-cross gating.
module attn_bank_chk
    import attn_pkg::*;
#(
    parameter int NUM_ANA = 4,
    parameter int NUM_DIG = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en_i,
    input logic [ADDR_W-1:0]        wr_addr_i,
    input logic [WORD_W-1:0]        wr_data_i,
    input logic [ANA_W*NUM_ANA-1:0] ana_atten_o,
    input logic [DIG_W*NUM_DIG-1:0] dig_atten_o
);
    localparam logic [ADDR_W-1:0] LAST_ADR = DIG_BASE + ADDR_W'(NUM_DIG - 1);

    logic rst_seen_q = 1'b0;

    // Records that the previous edge was a reset edge.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    assert_reset_defaults_R1: assert property (@(posedge clk)
        rst_seen_q |-> (ana_atten_o == {NUM_ANA{ANA_RESET}} &&
                        dig_atten_o == {NUM_DIG{DIG_RESET}}));

    assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_data_i[UPD_BIT]) |=> $stable(dig_atten_o));

    assert_commit_own_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == DIG_BASE && wr_data_i[UPD_BIT])
        |=> dig_atten_o[DIG_W-1:0] == $past(wr_data_i[DIG_W-1:0]));

    assert_ignore_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i < ANA_BASE || wr_addr_i > LAST_ADR))
        |=> $stable(dig_atten_o));
endmodule

bind attn_bank attn_bank_chk #(.NUM_ANA(NUM_ANA), .NUM_DIG(NUM_DIG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .ana_atten_o (ana_atten_o),
    .dig_atten_o (dig_atten_o)
);

// File: tb/attn_bank_tb.sv
// Bench: vector table of writes with expected outputs, then directed
// tests for the zero-cross, timeout, ignored-address and reset cases.
module attn_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [8:0]  wr_data = '0;
    logic [3:0]  sign = '0;
    logic [27:0] ana;
    logic [23:0] dig;
    int          errors = 0;
    int          checks = 0;

    always #2.5 clk = ~clk;

    attn_bank u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .ana_sign_i  (sign),
        .ana_atten_o (ana),
        .dig_atten_o (dig)
    );

    // Vector: addr, data, expected analog {a3,a2,a1,a0}, expected digital {d2,d1,d0}
    localparam int NV = 7;
    localparam logic [67:0] VEC [NV] = '{
        {7'h06, 9'h050, 7'h6B, 7'h6B, 7'h6B, 7'h6B, 8'hFF, 8'hFF, 8'hFF},
        {7'h0B, 9'h010, 7'h6B, 7'h6B, 7'h6B, 7'h6B, 8'hFF, 8'hFF, 8'hFF},
        {7'h07, 9'h160, 7'h6B, 7'h6B, 7'h60, 7'h50, 8'hFF, 8'hFF, 8'h10},
        {7'h0A, 9'h030, 7'h6B, 7'h6B, 7'h60, 7'h50, 8'hFF, 8'hFF, 8'h10},
        {7'h0C, 9'h1AA, 7'h30, 7'h30, 7'h30, 7'h30, 8'hFF, 8'hAA, 8'h10},
        {7'h0D, 9'h000, 7'h30, 7'h30, 7'h30, 7'h30, 8'hFF, 8'hAA, 8'h10},
        {7'h09, 9'h17F, 7'h7F, 7'h30, 7'h30, 7'h30, 8'h00, 8'hAA, 8'h10}
    };

    task automatic chk(input string req, input logic [27:0] ea, input logic [23:0] ed);
        checks++;
        if (ana !== ea || dig !== ed) begin
            errors++;
            $display("FAIL %s: ana=%h dig=%h expected ana=%h dig=%h", req, ana, dig, ea, ed);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [8:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset", {4{7'h6B}}, {3{8'hFF}});
        // Vector walk: R2 staging, R3 commit, R4 master, R5/R6 field decode
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][67:61], VEC[i][60:52]);
            chk($sformatf("R2/R3/R4/R5/R6 vector %0d", i), VEC[i][51:24], VEC[i][23:0]);
        end
        // R10: update bit not stored
        wr(7'h06, 9'h011);
        chk("R10 no commit", {7'h7F, 7'h30, 7'h30, 7'h30}, {8'h00, 8'hAA, 8'h10});
        wr(7'h0B, 9'h155);
        chk("R3 later commit", {7'h7F, 7'h30, 7'h30, 7'h11}, {8'h00, 8'hAA, 8'h55});
        // R7: zero-cross hold then release on sign change
        wr(7'h06, 9'h188);
        chk("R7 held", {7'h7F, 7'h30, 7'h30, 7'h11}, {8'h00, 8'hAA, 8'h55});
        sign[0] = 1'b1;
        @(negedge clk);
        chk("R7 released", {7'h7F, 7'h30, 7'h30, 7'h08}, {8'h00, 8'hAA, 8'h55});
        // R4: master write arms all; only channel 2 sees a sign change
        wr(7'h0A, 9'h1A0);
        chk("R4 master armed", {7'h7F, 7'h30, 7'h30, 7'h08}, {8'h00, 8'hAA, 8'h55});
        sign[2] = 1'b1;
        @(negedge clk);
        chk("R4 master ch2", {7'h7F, 7'h20, 7'h30, 7'h08}, {8'h00, 8'hAA, 8'h55});
        // R8: timeout release for the others
        repeat (1000) @(negedge clk);
        chk("R8 before timeout", {7'h7F, 7'h20, 7'h30, 7'h08}, {8'h00, 8'hAA, 8'h55});
        repeat (60) @(negedge clk);
        chk("R8 after timeout", {4{7'h20}}, {8'h00, 8'hAA, 8'h55});
        // R9: ignored addresses
        wr(7'h06, 9'h000);
        wr(7'h0E, 9'h1FF);
        wr(7'h05, 9'h1FF);
        chk("R9 ignored", {4{7'h20}}, {8'h00, 8'hAA, 8'h55});
        wr(7'h0D, 9'h1EE);
        chk("R9 pending kept", {7'h20, 7'h20, 7'h20, 7'h00}, {8'hEE, 8'hAA, 8'h55});
        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset mid-run", {4{7'h6B}}, {3{8'hFF}});
        wr(7'h0B, 9'h100);
        chk("R1 pending reset", {4{7'h6B}}, {8'hFF, 8'hFF, 8'h00});
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule